// File: doc/BRIEF.md
# Host Register Window and Interrupt Vectoring for a Network Adapter

This block is the slave front end that a host processor sees when it talks to a network adapter. It places eight word-wide registers inside a sixteen-byte I/O window. The host relocates that window by strapping a base selector. Host writes are steered to the transmit and receive register sets, and their values drive the channel engines. Host reads return status, the residual receive count, and the complemented node address. The channel engines report completion, error and collision events back through single-cycle pulses.

The block also collects three interrupt sources: transmit complete, receive complete and collision. It raises one request line and presents the vector of the most urgent pending source. A one-cycle acknowledge retires only the source that was being shown. The host bus is a plain synchronous strobe interface. A strobe is accepted in the cycle it is sampled and answered by an acknowledge one cycle later. There is no back-pressure, and the acknowledge never stretches.

The window base is `WIN_LO + 16*strap_base`. With the default `WIN_LO` of octal 760000, a strap value of 1 gives the usual window at octal 760020.

Top module: `nic_host_regs`

## Requirements
- R1: A strobe hits only when `host_addr[17:4]` equals the window base (octal 760000 + 16*`strap_base`) and `host_addr[0]` is 0. The register index is `host_addr[3:1]`. A hit asserts `host_ack` on the cycle after the strobe. A miss gives no ack and changes no register.
- R2: Index 7 reads `{8'h00, ~strap_node}`. Writes to index 7 have no effect.
- R3: Indices 0 (transmit count), 1 (transmit buffer), 3 (transmit start delay) and 5 (receive buffer) are write-only. They read as 0, and a written value appears on `tx_wc`, `tx_buf`, `tx_delay` or `rx_buf` one cycle after the strobe.
- R4: Index 4 stores `wdata[9:0]` as the receive count and reads back `{6'b0, count}`. Each `rx_word_evt` adds 1 modulo 1024.
- R5: The control/status words at index 2 (transmit) and index 6 (receive) share one layout: bit 15 error, bit 7 done, bit 6 interrupt enable, bit 1 accept-all (receive only, exported as `rx_promisc`), bit 0 enable (exported as `tx_go`/`rx_go`). Error and done cannot be written. Writing bit 0 as 1 clears both.
- R6: A done event sets done and clears enable. An error event sets the error bit.
- R7: `tx_col_evt` sets the transmit error bit, clears `tx_go` and raises a collision interrupt whatever the enable bits are.
- R8: A completion interrupt is raised only when that channel's done event arrives while its interrupt enable is 1 and its done bit is still 0.
- R9: While `irq_req` is high, `irq_vec` is `VEC_BASE` plus 0 for transmit complete, 4 for receive complete and octal 10 for collision. The default `VEC_BASE` is octal 400.
- R10: The priority among pending sources is collision, then transmit, then receive. `irq_ack` clears only the source shown on `irq_vec`, and the others stay pending.
- R11: After reset, every register is 0, `host_ack` is 0 and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 18 | Host byte address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_ack |
| host_ack | output | 1 | Access answered, one cycle after strobe |
| strap_base | input | 9 | Window base selector, 16-byte steps |
| strap_node | input | 8 | Node address straps |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_vec | output | 9 | Vector of the shown source |
| tx_wc | output | 16 | Transmit word count |
| tx_buf | output | 16 | Transmit buffer location |
| tx_delay | output | 16 | Transmit start delay |
| tx_go | output | 1 | Transmit enable |
| tx_done_evt | input | 1 | Transmit finished pulse |
| tx_err_evt | input | 1 | Transmit error pulse |
| tx_col_evt | input | 1 | Collision pulse |
| rx_wc | output | 10 | Receive residual count |
| rx_buf | output | 16 | Receive buffer location |
| rx_go | output | 1 | Receive enable |
| rx_promisc | output | 1 | Accept every frame |
| rx_done_evt | input | 1 | Receive finished pulse |
| rx_err_evt | input | 1 | Receive error pulse |
| rx_word_evt | input | 1 | Receive word stored pulse |

## Verification
Each result of a host access, including read data, the acknowledge and the channel outputs, is due one clock edge after the strobe is sampled. An event pulse updates status and the interrupt request at the edge that samples it, and an acknowledge changes `irq_vec` at the edge that samples it. The bench drives every input on the falling edge, holds it for one rising edge and samples at the next falling edge. Every check therefore looks exactly one register stage after its stimulus and never at an edge.

// File: rtl/nic_host_pkg.sv
package nic_host_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    IDX_TX_WC  = 3'd0,
    IDX_TX_BUF = 3'd1,
    IDX_TX_CSR = 3'd2,
    IDX_TX_DLY = 3'd3,
    IDX_RX_WC  = 3'd4,
    IDX_RX_BUF = 3'd5,
    IDX_RX_CSR = 3'd6,
    IDX_NODE   = 3'd7
  } reg_idx_e;

  // control/status bit positions shared by both channels
  localparam int CSR_ERR  = 15;
  localparam int CSR_DONE = 7;
  localparam int CSR_IE   = 6;
  localparam int CSR_PROM = 1;
  localparam int CSR_GO   = 0;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_COL  = 2'd1,
    SRC_TX   = 2'd2,
    SRC_RX   = 2'd3
  } irq_src_e;

  localparam int VOFF_TX  = 0;
  localparam int VOFF_RX  = 4;
  localparam int VOFF_COL = 8;
endpackage

// File: rtl/hostwin_decode.sv
module hostwin_decode
  import nic_host_pkg::*;
#(
  parameter int          ADDR_W = 18,
  parameter int          SEL_W  = 9,
  parameter logic [17:0] WIN_LO = 18'o760000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [SEL_W-1:0]  base_sel,
  output reg_idx_e          idx,
  output logic [7:0]        wr_sel,
  output logic              rd_hit,
  output logic              acc_hit
);
  localparam int STEP_SH = 4;

  logic [ADDR_W-1:0] base;
  logic              hit;

  assign base    = ADDR_W'(WIN_LO) + (ADDR_W'(base_sel) << STEP_SH);
  assign hit     = (addr[ADDR_W-1:STEP_SH] == base[ADDR_W-1:STEP_SH]) && !addr[0];
  assign idx     = reg_idx_e'(addr[STEP_SH-1:1]);
  assign rd_hit  = rd && hit;
  assign acc_hit = (rd || wr) && hit;

  for (genvar i = 0; i < 8; i++) begin : g_wsel
    assign wr_sel[i] = wr && hit && (addr[STEP_SH-1:1] == 3'(i));
  end
endmodule

// File: rtl/chan_regs.sv
module chan_regs
  import nic_host_pkg::*;
#(
  parameter bit IS_RX  = 1'b0,
  parameter int RXWC_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_wc,
  input  logic              wr_buf,
  input  logic              wr_csr,
  input  logic              done_evt,
  input  logic              err_evt,
  input  logic              abort_evt,
  input  logic              step_evt,
  output logic [DATA_W-1:0] csr_rd,
  output logic [DATA_W-1:0] wc_q,
  output logic [DATA_W-1:0] buf_q,
  output logic              intr_evt
);
  localparam int WC_W = IS_RX ? RXWC_W : DATA_W;

  logic [WC_W-1:0] cnt;
  logic            go, ie, prom, done, err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      buf_q <= '0;
    end else begin
      if (wr_wc)       cnt <= wdata[WC_W-1:0];
      else if (step_evt) cnt <= cnt + 1'b1;
      if (wr_buf) buf_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go <= 1'b0; ie <= 1'b0; prom <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      if (wr_csr) begin
        ie   <= wdata[CSR_IE];
        prom <= IS_RX & wdata[CSR_PROM];
        go   <= wdata[CSR_GO];
        if (wdata[CSR_GO]) begin
          done <= 1'b0;
          err  <= 1'b0;
        end
      end
      if (err_evt)   err <= 1'b1;
      if (abort_evt) go  <= 1'b0;
      if (done_evt) begin
        done <= 1'b1;
        go   <= 1'b0;
      end
    end
  end

  assign intr_evt = done_evt && ie && !done;

  always_comb begin
    csr_rd           = '0;
    csr_rd[CSR_ERR]  = err;
    csr_rd[CSR_DONE] = done;
    csr_rd[CSR_IE]   = ie;
    csr_rd[CSR_PROM] = prom;
    csr_rd[CSR_GO]   = go;
  end

  if (WC_W < DATA_W) begin : g_wc_ext
    assign wc_q = {{(DATA_W-WC_W){1'b0}}, cnt};
  end else begin : g_wc_full
    assign wc_q = cnt;
  end

  // R6: a done event leaves done set and enable cleared
  p_done_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (csr_rd[CSR_DONE] && !csr_rd[CSR_GO]));

  // R4: residual count advances by one per stored word
  p_wc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !wr_wc) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import nic_host_pkg::*;
#(
  parameter int             VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'o400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_col,
  input  logic             set_tx,
  input  logic             set_rx,
  input  logic             ack,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  logic     pend_col, pend_tx, pend_rx;
  irq_src_e sel;

  always_comb begin
    if (pend_col)     sel = SRC_COL;
    else if (pend_tx) sel = SRC_TX;
    else if (pend_rx) sel = SRC_RX;
    else              sel = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_col <= 1'b0; pend_tx <= 1'b0; pend_rx <= 1'b0;
    end else begin
      pend_col <= (pend_col && !(ack && sel == SRC_COL)) || set_col;
      pend_tx  <= (pend_tx  && !(ack && sel == SRC_TX))  || set_tx;
      pend_rx  <= (pend_rx  && !(ack && sel == SRC_RX))  || set_rx;
    end
  end

  assign req = pend_col || pend_tx || pend_rx;

  always_comb begin
    case (sel)
      SRC_COL: vec = VEC_BASE + VEC_W'(VOFF_COL);
      SRC_TX:  vec = VEC_BASE + VEC_W'(VOFF_TX);
      SRC_RX:  vec = VEC_BASE + VEC_W'(VOFF_RX);
      default: vec = '0;
    endcase
  end

  // R9: a raised request always shows one of the three vectors
  p_vec_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (vec == VEC_BASE || vec == VEC_BASE + VEC_W'(VOFF_RX) ||
             vec == VEC_BASE + VEC_W'(VOFF_COL)));

  // R10: without an acknowledge a request is never dropped
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);

  // R10: acknowledging the collision retires it unless a new one arrives
  p_col_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend_col && !set_col) |=> !pend_col);
endmodule

// File: rtl/nic_host_regs.sv
module nic_host_regs
  import nic_host_pkg::*;
#(
  parameter int               ADDR_W   = 18,
  parameter int               SEL_W    = 9,
  parameter int               NODE_W   = 8,
  parameter int               RXWC_W   = 10,
  parameter int               VEC_W    = 9,
  parameter logic [17:0]      WIN_LO   = 18'o760000,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'o400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ack,
  input  logic [SEL_W-1:0]  strap_base,
  input  logic [NODE_W-1:0] strap_node,
  output logic              irq_req,
  input  logic              irq_ack,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [DATA_W-1:0] tx_wc,
  output logic [DATA_W-1:0] tx_buf,
  output logic [DATA_W-1:0] tx_delay,
  output logic              tx_go,
  input  logic              tx_done_evt,
  input  logic              tx_err_evt,
  input  logic              tx_col_evt,
  output logic [RXWC_W-1:0] rx_wc,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_go,
  output logic              rx_promisc,
  input  logic              rx_done_evt,
  input  logic              rx_err_evt,
  input  logic              rx_word_evt
);
  reg_idx_e          idx;
  logic [7:0]        wr_sel;
  logic              rd_hit, acc_hit;
  logic [DATA_W-1:0] tx_csr, rx_csr, rx_wc16, rd_mux;
  logic              tx_intr, rx_intr;

  hostwin_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .WIN_LO(WIN_LO)) u_dec (
    .addr(host_addr), .wr(host_wr), .rd(host_rd), .base_sel(strap_base),
    .idx(idx), .wr_sel(wr_sel), .rd_hit(rd_hit), .acc_hit(acc_hit)
  );

  chan_regs #(.IS_RX(1'b0), .RXWC_W(RXWC_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .wdata(host_wdata),
    .wr_wc(wr_sel[IDX_TX_WC]), .wr_buf(wr_sel[IDX_TX_BUF]), .wr_csr(wr_sel[IDX_TX_CSR]),
    .done_evt(tx_done_evt), .err_evt(tx_err_evt || tx_col_evt),
    .abort_evt(tx_col_evt), .step_evt(1'b0),
    .csr_rd(tx_csr), .wc_q(tx_wc), .buf_q(tx_buf), .intr_evt(tx_intr)
  );

  chan_regs #(.IS_RX(1'b1), .RXWC_W(RXWC_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .wdata(host_wdata),
    .wr_wc(wr_sel[IDX_RX_WC]), .wr_buf(wr_sel[IDX_RX_BUF]), .wr_csr(wr_sel[IDX_RX_CSR]),
    .done_evt(rx_done_evt), .err_evt(rx_err_evt),
    .abort_evt(1'b0), .step_evt(rx_word_evt),
    .csr_rd(rx_csr), .wc_q(rx_wc16), .buf_q(rx_buf), .intr_evt(rx_intr)
  );

  irq_arb #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_col(tx_col_evt), .set_tx(tx_intr),
    .set_rx(rx_intr), .ack(irq_ack), .req(irq_req), .vec(irq_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_delay <= '0;
    else if (wr_sel[IDX_TX_DLY]) tx_delay <= host_wdata;
  end

  assign tx_go      = tx_csr[CSR_GO];
  assign rx_go      = rx_csr[CSR_GO];
  assign rx_promisc = rx_csr[CSR_PROM];
  assign rx_wc      = rx_wc16[RXWC_W-1:0];

  always_comb begin
    case (idx)
      IDX_TX_CSR: rd_mux = tx_csr;
      IDX_RX_CSR: rd_mux = rx_csr;
      IDX_RX_WC:  rd_mux = rx_wc16;
      IDX_NODE:   rd_mux = {{(DATA_W-NODE_W){1'b0}}, ~strap_node};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack   <= acc_hit;
      host_rdata <= rd_hit ? rd_mux : '0;
    end
  end

  // R1: an acknowledge only follows a strobe that hit the window
  p_ack_follows_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> $past(acc_hit));

  // R1: a hitting strobe is always answered next cycle
  p_hit_answered_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> host_ack);

  // R7: a collision stops the transmitter
  p_col_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_col_evt |=> (!tx_go && irq_req));
endmodule

// File: tb/test_nic_host_regs.sv
module test_nic_host_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_ack;
  logic [8:0]  strap_base = 9'd1;
  logic [7:0]  strap_node = 8'hA5;
  logic        irq_req;
  logic        irq_ack = 1'b0;
  logic [8:0]  irq_vec;
  logic [15:0] tx_wc, tx_buf, tx_delay;
  logic        tx_go;
  logic        tx_done_evt = 1'b0, tx_err_evt = 1'b0, tx_col_evt = 1'b0;
  logic [9:0]  rx_wc;
  logic [15:0] rx_buf;
  logic        rx_go, rx_promisc;
  logic        rx_done_evt = 1'b0, rx_err_evt = 1'b0, rx_word_evt = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nic_host_regs i_nic_host_regs (.*);

  function automatic logic [17:0] addr_of(input logic [8:0] sel, input int idx);
    return 18'o760000 + 18'(sel) * 18'd16 + 18'(idx * 2);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [17:0] a, input logic [15:0] d, output logic ack);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    ack = host_ack;
  endtask

  task automatic bus_rd(input logic [17:0] a, output logic [15:0] d, output logic ack);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata; ack = host_ack;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R11", "ack", 32'(host_ack), 32'd0);
    check("R11", "irq_req", 32'(irq_req), 32'd0);
    check("R11", "tx_go/rx_go", {tx_go, rx_go}, 32'd0);
    check("R11", "tx_wc", 32'(tx_wc), 32'd0);
  endtask

  task automatic t_node();
    logic [15:0] d; logic a;
    bus_rd(addr_of(1, 7), d, a);
    check("R2", "node read", 32'(d), 32'h005A);
    check("R1", "ack on read hit", 32'(a), 32'd1);
    bus_wr(addr_of(1, 7), 16'h1234, a);
    bus_rd(addr_of(1, 7), d, a);
    check("R2", "node after write", 32'(d), 32'h005A);
  endtask

  task automatic t_window();
    logic a;
    bus_wr(18'o760020, 16'h1111, a);
    check("R1", "ack at default base", 32'(a), 32'd1);
    check("R1", "tx_wc written", 32'(tx_wc), 32'h1111);
    bus_wr(18'o760040, 16'h2222, a);
    check("R1", "no ack outside", 32'(a), 32'd0);
    check("R1", "tx_wc unchanged outside", 32'(tx_wc), 32'h1111);
    bus_wr(18'o760021, 16'h3333, a);
    check("R1", "no ack odd address", 32'(a), 32'd0);
    strap_base = 9'd9;
    bus_wr(18'o760220, 16'h4444, a);
    check("R1", "ack relocated base", 32'(a), 32'd1);
    check("R1", "tx_wc relocated", 32'(tx_wc), 32'h4444);
    bus_wr(18'o760020, 16'h5555, a);
    check("R1", "old base no longer hits", 32'(tx_wc), 32'h4444);
    strap_base = 9'd1;
  endtask

  task automatic t_wronly();
    logic [15:0] d; logic a;
    bus_wr(addr_of(1, 1), 16'hBEEF, a);
    bus_wr(addr_of(1, 3), 16'h0123, a);
    bus_wr(addr_of(1, 5), 16'hCAFE, a);
    check("R3", "tx_buf", 32'(tx_buf), 32'hBEEF);
    check("R3", "tx_delay", 32'(tx_delay), 32'h0123);
    check("R3", "rx_buf", 32'(rx_buf), 32'hCAFE);
    bus_rd(addr_of(1, 0), d, a); check("R3", "read idx0", 32'(d), 32'd0);
    bus_rd(addr_of(1, 1), d, a); check("R3", "read idx1", 32'(d), 32'd0);
    bus_rd(addr_of(1, 3), d, a); check("R3", "read idx3", 32'(d), 32'd0);
    bus_rd(addr_of(1, 5), d, a); check("R3", "read idx5", 32'(d), 32'd0);
  endtask

  task automatic t_rxwc();
    logic [15:0] d; logic a;
    bus_wr(addr_of(1, 4), 16'hFFFE, a);
    bus_rd(addr_of(1, 4), d, a);
    check("R4", "rx count masked", 32'(d), 32'h03FE);
    pulse(rx_word_evt);
    pulse(rx_word_evt);
    bus_rd(addr_of(1, 4), d, a);
    check("R4", "rx count wraps", 32'(d), 32'h0000);
    check("R4", "rx_wc port", 32'(rx_wc), 32'd0);
  endtask

  task automatic t_csr();
    logic [15:0] d; logic a;
    bus_wr(addr_of(1, 2), 16'hFFFF, a);
    bus_rd(addr_of(1, 2), d, a);
    check("R5", "tx csr read-only bits", 32'(d), 32'h0041);
    check("R5", "tx_go", 32'(tx_go), 32'd1);
    bus_wr(addr_of(1, 6), 16'h0043, a);
    bus_rd(addr_of(1, 6), d, a);
    check("R5", "rx csr", 32'(d), 32'h0043);
    check("R5", "rx_promisc/rx_go", {rx_promisc, rx_go}, 32'd3);
  endtask

  task automatic t_done();
    logic [15:0] d; logic a;
    pulse(tx_done_evt);
    check("R8", "tx irq raised", 32'(irq_req), 32'd1);
    check("R9", "tx vector", 32'(irq_vec), 32'o400);
    bus_rd(addr_of(1, 2), d, a);
    check("R6", "tx done, go cleared", 32'(d), 32'h00C0);
    do_ack();
    check("R10", "irq cleared by ack", 32'(irq_req), 32'd0);
    pulse(tx_err_evt);
    bus_rd(addr_of(1, 2), d, a);
    check("R6", "tx error set", 32'(d), 32'h80C0);
    bus_wr(addr_of(1, 2), 16'h0041, a);
    bus_rd(addr_of(1, 2), d, a);
    check("R5", "enable clears done/err", 32'(d), 32'h0041);
  endtask

  task automatic t_gate();
    logic [15:0] d; logic a;
    bus_wr(addr_of(1, 6), 16'h0001, a);
    pulse(rx_done_evt);
    check("R8", "no irq with ie=0", 32'(irq_req), 32'd0);
    bus_rd(addr_of(1, 6), d, a);
    check("R6", "rx done set", 32'(d), 32'h0080);
    bus_wr(addr_of(1, 6), 16'h0040, a);
    pulse(rx_done_evt);
    check("R8", "no irq when done already set", 32'(irq_req), 32'd0);
  endtask

  task automatic t_col();
    logic [15:0] d; logic a;
    bus_wr(addr_of(1, 2), 16'h0001, a);
    pulse(tx_col_evt);
    check("R7", "collision irq", 32'(irq_req), 32'd1);
    check("R7", "collision vector", 32'(irq_vec), 32'o410);
    check("R7", "tx_go cleared", 32'(tx_go), 32'd0);
    bus_rd(addr_of(1, 2), d, a);
    check("R7", "tx error bit", 32'(d), 32'h8000);
  endtask

  task automatic t_prio();
    logic a;
    bus_wr(addr_of(1, 2), 16'h0041, a);
    bus_wr(addr_of(1, 6), 16'h0041, a);
    @(negedge clk);
    tx_done_evt = 1'b1; rx_done_evt = 1'b1;
    @(negedge clk);
    tx_done_evt = 1'b0; rx_done_evt = 1'b0;
    check("R10", "collision first", 32'(irq_vec), 32'o410);
    do_ack();
    check("R10", "transmit second", 32'(irq_vec), 32'o400);
    do_ack();
    check("R10", "receive third", 32'(irq_vec), 32'o404);
    check("R9", "req still high", 32'(irq_req), 32'd1);
    do_ack();
    check("R10", "all retired", 32'(irq_req), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_node();
    t_window();
    t_wronly();
    t_rxwc();
    t_csr();
    t_done();
    t_gate();
    t_col();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule